// File: doc/BRIEF.md
# Dual-Edge Capture Timer

This block times an external digital input, such as a speed pulse or a zero-cross signal, against a free-running 16-bit counter clocked by the system clock. The input first passes through a synchroniser. Each falling edge copies the count into a falling-edge capture register, and each rising edge copies it into a separate rising-edge capture register. Software can then derive pulse widths and periods from the difference between two captures.

Every accepted capture raises an interrupt request. The request stays up until it is acknowledged. The block checks the input against minimum high-time, low-time and period limits. An edge that ends a level which is too short, or that completes a period which is too short, is rejected: it latches nothing, raises no request and sets an error flag. A read strobe, given when software reads the capture registers, clears the sticky flags.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset the count, both capture registers, the interrupt request and all three flags are 0.
- R2: While `enable` is 1 the count rises by one per clock and wraps from 0xFFFF to 0. The wrap sets `overflowFlag`. A `capRead` pulse clears the flag, but a wrap in the same cycle as the pulse leaves it set.
- R3: An accepted falling edge loads `fallCap` with the count value that was visible in the cycle before the load. The load happens on the second clock edge after the clock edge that first samples the new pin level, so it is within 4 clocks of the edge.
- R4: An accepted rising edge loads `riseCap` in the same way and with the same timing as R3.
- R5: `irqReq` rises on the same clock edge as the capture load and stays 1 until a cycle with `irqAck` high. If a new capture arrives in the acknowledge cycle, the request stays 1.
- R6: A capture that arrives while `irqReq` is 1 and is not being acknowledged sets `overrunFlag`. A `capRead` pulse clears it, and a set in the same cycle wins.
- R7: A falling edge that ends a high level shorter than MIN_HIGH clocks (default 4) is rejected. So is a rising edge that ends a low level shorter than MIN_LOW clocks (default 4). A rejected edge leaves both capture registers and `irqReq` unchanged and sets `widthErr`, which `capRead` clears.
- R8: An edge is also rejected, as in R7, when the level it ends plus the level before it lasted fewer than MIN_PERIOD clocks (default 8).
- R9: While `enable` is 0 the count holds. Pin edges then latch nothing, raise no request and set no flag.
- R10: The first edge after reset passes the limit checks, because the level-length history starts at its saturated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the counter and allows captures |
| capPin | input | 1 | Asynchronous input being measured |
| irqAck | input | 1 | Acknowledge; clears the pending request |
| capRead | input | 1 | Strobe on a software read of the capture registers; clears the flags |
| countNow | output | 16 | Live counter value |
| fallCap | output | 16 | Count latched at the last accepted falling edge |
| riseCap | output | 16 | Count latched at the last accepted rising edge |
| irqReq | output | 1 | Pending capture interrupt request |
| overflowFlag | output | 1 | Sticky counter-wrap flag |
| overrunFlag | output | 1 | Sticky flag: capture while a request was pending |
| widthErr | output | 1 | Sticky flag: edge rejected by the limit checks |

## Verification
A pin level driven before clock edge N is sampled at edge N. The capture register, `irqReq` and `widthErr` change at edge N+2. The counter and the flags that `irqAck` or `capRead` affect change on the first edge that samples the strobe. The bench keeps a behavioural model that is advanced on every rising edge from the inputs it drove. The model delays the pin through a history queue and tracks level lengths with plain integers. The bench compares every output against the model at the following falling edge, so each result is checked in exactly the cycle it is due. The bench overrides MIN_PERIOD to 10 so that the period limit can be violated without breaking the high-time and low-time limits.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef struct packed {
    logic countEn;
    logic latchFall;
    logic latchRise;
    logic clearFlags;
  } ctStrobes_t;
endpackage

// File: rtl/ct_sync.sv
module ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] shiftReg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shiftReg <= '0;
        else       shiftReg <= dIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shiftReg <= '0;
        else       shiftReg <= {shiftReg[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign dOut = shiftReg[STAGES-1];
endmodule

// File: rtl/ct_ctrl.sv
module ct_ctrl
  import ct_pkg::*;
#(
  parameter int MIN_HIGH   = 4,
  parameter int MIN_LOW    = 4,
  parameter int MIN_PERIOD = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       pinSync,
  input  logic       irqAck,
  input  logic       capRead,
  output ctStrobes_t strobes,
  output logic       irqReq,
  output logic       overrunFlag,
  output logic       widthErr
);
  localparam int SAT   = (MIN_PERIOD > MIN_HIGH) ? ((MIN_PERIOD > MIN_LOW) ? MIN_PERIOD : MIN_LOW)
                                                 : ((MIN_HIGH > MIN_LOW) ? MIN_HIGH : MIN_LOW);
  localparam int LEN_W = $clog2(SAT + 1);

  logic             pinDly;
  logic [LEN_W-1:0] runLen;
  logic [LEN_W-1:0] prevLen;
  logic             edgeSeen;
  logic             isRise;
  logic             levelOk;
  logic             periodOk;
  logic             lenOk;
  logic             capValid;
  logic             capReject;

  assign edgeSeen  = pinSync != pinDly;
  assign isRise    = pinSync;
  assign levelOk   = isRise ? (runLen >= LEN_W'(MIN_LOW)) : (runLen >= LEN_W'(MIN_HIGH));
  assign periodOk  = ({1'b0, prevLen} + {1'b0, runLen}) >= (LEN_W+1)'(MIN_PERIOD);
  assign lenOk     = levelOk && periodOk;
  assign capValid  = edgeSeen && enable && lenOk;
  assign capReject = edgeSeen && enable && !lenOk;

  always_comb begin
    strobes.countEn    = enable;
    strobes.latchFall  = capValid && !isRise;
    strobes.latchRise  = capValid && isRise;
    strobes.clearFlags = capRead;
  end

  // level-length history, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinDly  <= 1'b0;
      runLen  <= LEN_W'(SAT);
      prevLen <= LEN_W'(SAT);
    end else begin
      pinDly <= pinSync;
      if (edgeSeen) begin
        prevLen <= runLen;
        runLen  <= LEN_W'(1);
      end else if (runLen < LEN_W'(SAT)) begin
        runLen <= runLen + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq      <= 1'b0;
      overrunFlag <= 1'b0;
      widthErr    <= 1'b0;
    end else begin
      if (capValid)    irqReq <= 1'b1;
      else if (irqAck) irqReq <= 1'b0;

      if (capValid && irqReq && !irqAck) overrunFlag <= 1'b1;
      else if (capRead)                  overrunFlag <= 1'b0;

      if (capReject)    widthErr <= 1'b1;
      else if (capRead) widthErr <= 1'b0;
    end
  end

  a_r5_irq_pending: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> irqReq);
  a_r5_irq_ack: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !strobes.latchFall && !strobes.latchRise) |=> !irqReq);
  a_r6_overrun: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.latchFall || strobes.latchRise) && irqReq && !irqAck) |=> overrunFlag);
  a_r7_reject: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSeen && enable && !lenOk) |=> widthErr);
  a_r3_one_edge: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.latchFall, strobes.latchRise}));
  a_r9_no_capture: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !(strobes.latchFall || strobes.latchRise));
endmodule

// File: rtl/ct_datapath.sv
module ct_datapath
  import ct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctStrobes_t       strobes,
  output logic [CNT_W-1:0] countNow,
  output logic [CNT_W-1:0] fallCap,
  output logic [CNT_W-1:0] riseCap,
  output logic             overflowFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrapNow;
  assign wrapNow = strobes.countEn && (countNow == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countNow     <= '0;
      overflowFlag <= 1'b0;
    end else begin
      if (strobes.countEn) countNow <= countNow + CNT_W'(1);
      if (wrapNow)                 overflowFlag <= 1'b1;
      else if (strobes.clearFlags) overflowFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallCap <= '0;
      riseCap <= '0;
    end else begin
      if (strobes.latchFall) fallCap <= countNow;
      if (strobes.latchRise) riseCap <= countNow;
    end
  end

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.countEn && countNow == CNT_MAX) |=> (countNow == '0 && overflowFlag));
  a_r3_fall_value: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchFall |=> fallCap == $past(countNow));
  a_r4_rise_value: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchRise |=> riseCap == $past(countNow));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.countEn |=> $stable(countNow));
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 4,
  parameter int MIN_LOW     = 4,
  parameter int MIN_PERIOD  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             capPin,
  input  logic             irqAck,
  input  logic             capRead,
  output logic [CNT_W-1:0] countNow,
  output logic [CNT_W-1:0] fallCap,
  output logic [CNT_W-1:0] riseCap,
  output logic             irqReq,
  output logic             overflowFlag,
  output logic             overrunFlag,
  output logic             widthErr
);
  logic       pinSync;
  ctStrobes_t strobes;

  ct_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .dIn(capPin), .dOut(pinSync)
  );

  ct_ctrl #(.MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW), .MIN_PERIOD(MIN_PERIOD)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .pinSync(pinSync),
    .irqAck(irqAck), .capRead(capRead), .strobes(strobes),
    .irqReq(irqReq), .overrunFlag(overrunFlag), .widthErr(widthErr)
  );

  ct_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .countNow(countNow),
    .fallCap(fallCap), .riseCap(riseCap), .overflowFlag(overflowFlag)
  );
endmodule

// File: tb/edge_capture_timer_tb_top.sv
`timescale 1ns/1ps
module edge_capture_timer_tb_top;
  localparam int MH = 4;
  localparam int ML = 4;
  localparam int MP = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic capPin = 1'b0;
  logic irqAck = 1'b0;
  logic capRead = 1'b0;
  logic [15:0] countNow, fallCap, riseCap;
  logic irqReq, overflowFlag, overrunFlag, widthErr;

  always #5 clk = ~clk;

  edge_capture_timer #(.MIN_PERIOD(MP)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .capPin(capPin),
    .irqAck(irqAck), .capRead(capRead), .countNow(countNow),
    .fallCap(fallCap), .riseCap(riseCap), .irqReq(irqReq),
    .overflowFlag(overflowFlag), .overrunFlag(overrunFlag), .widthErr(widthErr)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference
  int hist[$] = '{0, 0, 0};
  logic [15:0] mCnt = 0, mFall = 0, mRise = 0;
  bit mIrq = 0, mOvr = 0, mOvf = 0, mErr = 0;
  int runLen = MP, prevLen = MP;

  always @(posedge clk) begin
    if (!rstN) begin
      hist = '{0, 0, 0};
      mCnt = 0; mFall = 0; mRise = 0;
      mIrq = 0; mOvr = 0; mOvf = 0; mErr = 0;
      runLen = MP; prevLen = MP;
    end else begin
      bit edgeNow, rising, ok, valid;
      edgeNow = hist[1] != hist[2];
      rising  = hist[1] == 1;
      ok = (runLen >= (rising ? ML : MH)) && (prevLen + runLen >= MP);
      valid = edgeNow && enable && ok;
      if (valid && !rising) mFall = mCnt;
      if (valid && rising)  mRise = mCnt;
      if (valid && mIrq && !irqAck) mOvr = 1; else if (capRead) mOvr = 0;
      if (valid) mIrq = 1; else if (irqAck) mIrq = 0;
      if (edgeNow && enable && !ok) mErr = 1; else if (capRead) mErr = 0;
      if (enable && mCnt == 16'hFFFF) mOvf = 1; else if (capRead) mOvf = 0;
      if (enable) mCnt = mCnt + 16'd1;
      if (edgeNow) begin prevLen = runLen; runLen = 1; end
      else if (runLen < MP) runLen++;
      hist.push_front(int'(capPin));
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R2/R9 countNow", countNow, mCnt);
      chk("R3 fallCap", fallCap, mFall);
      chk("R4 riseCap", riseCap, mRise);
      chk("R5 irqReq", irqReq, mIrq);
      chk("R6 overrunFlag", overrunFlag, mOvr);
      chk("R7/R8 widthErr", widthErr, mErr);
      chk("R2 overflowFlag", overflowFlag, mOvf);
    end
  end

  task automatic hold(bit v, int n);
    capPin = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic ack();
    irqAck = 1; @(negedge clk); irqAck = 0;
  endtask

  task automatic rd();
    capRead = 1; @(negedge clk); capRead = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset irq", irqReq, 0);
    chk("R1 reset count", countNow, 0);
    rstN = 1;
    hold(0, 5);
    enable = 1;
    hold(0, 10);
    // R10 first edge accepted, R3/R4 captures
    hold(1, 6); hold(0, 12);
    chk("R10 first rise irq", irqReq, 1);
    ack();
    hold(1, 7); hold(0, 9);
    ack();
    // R5 ack in same cycle as capture
    hold(1, 5);
    capPin = 0; repeat (2) @(negedge clk);
    irqAck = 1; @(negedge clk); irqAck = 0;
    hold(0, 8);
    ack();
    // R6 overrun: two captures without ack
    hold(1, 6); hold(0, 6); hold(1, 6);
    rd(); ack();
    hold(0, 8);
    ack();
    // R7 short high and short low
    hold(1, 2); hold(0, 8);
    hold(1, 6); hold(0, 2); hold(1, 8);
    rd(); ack();
    // R8 period too short (4+4 < 10)
    hold(0, 20); hold(1, 4); hold(0, 4); hold(1, 10);
    ack(); rd();
    hold(0, 10); ack();
    // R9 disabled: no captures, counter holds
    enable = 0;
    hold(1, 6); hold(0, 6); hold(1, 3); hold(0, 8);
    enable = 1;
    // R2 wrap and clear
    hold(0, 66000);
    rd();
    hold(1, 6); hold(0, 8);
    ack();
    // read coinciding with nothing pending
    rd();
    hold(0, 5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    done = 1;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule